// File: doc/BRIEF.md
# Single-Shot and Pulse-Width Waveform Generator

This block turns a 16-bit timer count into a waveform on one output pin. It has two modes. In single-shot mode a selected edge on a trigger input starts one pulse. The pulse ends when the count reaches the end-of-pulse compare value, and the block then waits for the next qualifying edge. In pulse-width mode the block runs without a trigger. The end-of-pulse compare value marks where the active part of each period stops, and the period compare value restarts the period.

The block owns its counter. On every restart the counter is loaded with 0xFFFC, and it advances only on cycles where the tick enable is high. Two level inputs choose the pin value during the pulse and outside it. Both compare values are latched into shadow copies at each restart, so rewriting them in the middle of a period does not disturb that period. Each compare match raises a one-cycle flag that an interrupt controller can collect.

Top module: `pulse_pwm_gen`

## Requirements
- R1: While out of reset and idle, `wave_out` equals `lvl_idle`, both match flags are 0 and `cnt_out` reads 0xFFFC.
- R2: With `pwm_mode`=0, `enable`=1 and the block idle, a rising edge of `trig_in` (when `trig_rise`=1) or a falling edge (when `trig_rise`=0) is seen at the next clock edge. After that edge `wave_out` equals `lvl_active`.
- R3: A pulse lasts ((E - 0xFFFC) mod 2^16) + 1 tick cycles, where E is the latched end-of-pulse value. When it ends, `wave_out` returns to `lvl_idle` and `match_end` is 1 for exactly the first cycle after the pulse.
- R4: In single-shot mode, trigger edges that arrive during a pulse are ignored. After a pulse the output stays at `lvl_idle` until a new qualifying edge arrives.
- R5: With `pwm_mode`=1 and `enable`=1, the active part of each period lasts ((E - 0xFFFC) mod 2^16) + 1 tick cycles and the whole period lasts ((P - 0xFFFC) mod 2^16) + 1 tick cycles. `match_period` is 1 in the first active cycle of each restarted period.
- R6: When the period match comes before or together with the end-of-pulse match, the period match wins. The output then stays at `lvl_active` and `match_end` never rises.
- R7: The counter advances, and compares are evaluated, only on cycles with `tick`=1. A stalled tick lengthens the pulse by the number of stalled cycles.
- R8: Values written to `cmp_end` and `cmp_period` take effect only at the next pulse start or period restart.
- R9: When `enable` is 0 the block returns to idle at the next clock edge: the output goes to `lvl_idle` and the counter goes to 0xFFFC.
- R10: Every pulse start and period restart loads the counter with 0xFFFC. The count is visible on `cnt_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; 0 forces idle |
| pwm_mode | input | 1 | 1 selects pulse-width mode, 0 selects single-shot mode |
| tick | input | 1 | Counter advance enable |
| trig_in | input | 1 | Trigger input for single-shot mode |
| trig_rise | input | 1 | 1 triggers on a rising edge, 0 on a falling edge |
| lvl_active | input | 1 | Pin level during the pulse |
| lvl_idle | input | 1 | Pin level outside the pulse |
| cmp_end | input | 16 | End-of-pulse compare value |
| cmp_period | input | 16 | Period compare value |
| wave_out | output | 1 | Waveform pin |
| cnt_out | output | 16 | Current counter value |
| match_end | output | 1 | One-cycle end-of-pulse match flag |
| match_period | output | 1 | One-cycle period match flag |

## Verification
The bench uses the end value 0xFFFE, just ahead of the counter wrap. A design that reloads to zero, or that mis-handles the wrap, would then give a pulse thousands of cycles long instead of three. Trigger edges are toggled in the middle of a pulse, and the bench checks that the pulse neither restarts nor stretches. It also checks that the output stays idle afterwards, because a generator that free-runs would pulse again. The end-of-pulse value is lowered below the current count mid-pulse: without shadow copies that match is missed and the pulse runs on to the period match. In the case where the period is shorter than the pulse, a wrong priority would produce glitches or stray end flags.

// File: rtl/pulse_pwm_gen.sv
module pulse_pwm_gen #(
  parameter int W = 16,
  parameter logic [W-1:0] RELOAD = {{(W-3){1'b1}}, 3'b100}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         pwm_mode,
  input  logic         tick,
  input  logic         trig_in,
  input  logic         trig_rise,
  input  logic         lvl_active,
  input  logic         lvl_idle,
  input  logic [W-1:0] cmp_end,
  input  logic [W-1:0] cmp_period,
  output logic         wave_out,
  output logic [W-1:0] cnt_out,
  output logic         match_end,
  output logic         match_period
);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_PULSE = 2'd1, ST_TAIL = 2'd2} state_t;

  state_t       state;
  logic [W-1:0] cnt, sh_end, sh_per;
  logic         trig_q;

  wire edge_seen = trig_rise ? (trig_in & ~trig_q) : (~trig_in & trig_q);
  wire start     = pwm_mode | edge_seen;
  wire per_hit   = pwm_mode && (cnt == sh_per);
  wire end_hit   = (state == ST_PULSE) && (cnt == sh_end);

  assign wave_out = (state == ST_PULSE) ? lvl_active : lvl_idle;
  assign cnt_out  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= RELOAD;
      sh_end       <= '0;
      sh_per       <= '0;
      trig_q       <= 1'b0;
      match_end    <= 1'b0;
      match_period <= 1'b0;
    end else begin
      trig_q       <= trig_in;
      match_end    <= 1'b0;
      match_period <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;
        cnt   <= RELOAD;
      end else if (state == ST_IDLE) begin
        if (start) begin
          state  <= ST_PULSE;
          cnt    <= RELOAD;
          sh_end <= cmp_end;
          sh_per <= cmp_period;
        end
      end else if (tick) begin
        if (per_hit) begin
          match_period <= 1'b1;
          state        <= ST_PULSE;
          cnt          <= RELOAD;
          sh_end       <= cmp_end;
          sh_per       <= cmp_period;
        end else if (end_hit) begin
          match_end <= 1'b1;
          if (pwm_mode) begin
            state <= ST_TAIL;
            cnt   <= cnt + W'(1);
          end else begin
            state <= ST_IDLE;
            cnt   <= RELOAD;
          end
        end else if (state == ST_TAIL && !pwm_mode) begin
          state <= ST_IDLE;
          cnt   <= RELOAD;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pulse_pwm_gen_chk.sv
module pulse_pwm_gen_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] RELOAD = {{(W-3){1'b1}}, 3'b100}
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         pwm_mode,
  input logic         tick,
  input logic         lvl_idle,
  input logic         wave_out,
  input logic [W-1:0] cnt_out,
  input logic         match_end,
  input logic         match_period,
  input logic [1:0]   state,
  input logic [W-1:0] sh_end
);

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> (wave_out == lvl_idle));

  // R3
  end_flag_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_end |-> (wave_out == lvl_idle));

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_end && match_period));

  // R7
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && enable && state != 2'd0) |=> $stable(cnt_out));

  // R4
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && !pwm_mode && enable && !(tick && cnt_out == sh_end)) |=> (state == 2'd1));

  // R9
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == 2'd0 && cnt_out == RELOAD));

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_period |-> (cnt_out == RELOAD));

endmodule

bind pulse_pwm_gen pulse_pwm_gen_chk #(.W(W), .RELOAD(RELOAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_mode(pwm_mode), .tick(tick),
  .lvl_idle(lvl_idle), .wave_out(wave_out), .cnt_out(cnt_out),
  .match_end(match_end), .match_period(match_period), .state(state), .sh_end(sh_end)
);

// File: tb/pulse_pwm_gen_bench.sv
module pulse_pwm_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, pwm_mode = 1'b0, tick = 1'b1;
  logic        trig_in = 1'b0, trig_rise = 1'b1;
  logic        lvl_active = 1'b0, lvl_idle = 1'b1;
  logic [15:0] cmp_end = 16'd0, cmp_period = 16'd0;
  logic        wave_out, match_end, match_period;
  logic [15:0] cnt_out;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pulse_pwm_gen u_pulse_pwm_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pwm_mode(pwm_mode), .tick(tick),
    .trig_in(trig_in), .trig_rise(trig_rise), .lvl_active(lvl_active), .lvl_idle(lvl_idle),
    .cmp_end(cmp_end), .cmp_period(cmp_period), .wave_out(wave_out), .cnt_out(cnt_out),
    .match_end(match_end), .match_period(match_period)
  );

  // {end value, period value, expected active cycles, expected inactive cycles}
  localparam logic [63:0] PWM_VEC [3] = '{
    {16'd2,      16'd5,  16'd7, 16'd3},
    {16'd0,      16'd10, 16'd5, 16'd10},
    {16'hFFFE,   16'd3,  16'd3, 16'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts one full active run and the following inactive run
  task automatic measure(output int hi, output int lo, output bit ef, output bit pf);
    int guard = 0;
    hi = 0; lo = 0; ef = 0; pf = 0;
    while (wave_out == lvl_active && guard < 2000) begin step(); guard++; end
    while (wave_out != lvl_active && guard < 2000) begin step(); guard++; end
    while (wave_out == lvl_active && guard < 2000) begin hi++; step(); guard++; end
    ef = match_end;
    while (wave_out != lvl_active && guard < 2000) begin lo++; step(); guard++; end
    pf = match_period;
  endtask

  task automatic fire_edge();
    trig_in = trig_rise ? 1'b1 : 1'b0;
    step();
  endtask

  initial begin
    int hi, lo, n;
    bit ef, pf;
    logic [15:0] held;
    step(3);
    rst_n = 1'b1;
    step();
    chk(wave_out == 1'b1, "R1 idle level", wave_out, 1);
    chk(!match_end && !match_period, "R1 flags", match_end + match_period, 0);
    chk(cnt_out == 16'hFFFC, "R1 counter", cnt_out, 16'hFFFC);
    lvl_active = 1'b1; lvl_idle = 1'b0;
    step();
    chk(wave_out == 1'b0, "R1 idle follows level", wave_out, 0);

    // pulse-width table
    pwm_mode = 1'b1;
    for (int v = 0; v < 3; v++) begin
      enable = 1'b0;
      cmp_end = PWM_VEC[v][63:48];
      cmp_period = PWM_VEC[v][47:32];
      step();
      enable = 1'b1;
      measure(hi, lo, ef, pf);
      chk(hi == int'(PWM_VEC[v][31:16]), "R5 active length", hi, int'(PWM_VEC[v][31:16]));
      chk(lo == int'(PWM_VEC[v][15:0]), "R5 inactive length", lo, int'(PWM_VEC[v][15:0]));
      chk(ef, "R3 end flag", ef, 1);
      chk(pf, "R5 period flag", pf, 1);
    end

    // R6: period shorter than pulse
    enable = 1'b0; cmp_end = 16'd6; cmp_period = 16'd3; step();
    enable = 1'b1; step();
    n = 0; hi = 0; ef = 0;
    for (int i = 0; i < 30; i++) begin
      if (wave_out != 1'b1) hi++;
      if (match_end) ef = 1;
      if (match_period) n++;
      step();
    end
    chk(hi == 0, "R6 output stays active", hi, 0);
    chk(!ef, "R6 no end flag", ef, 0);
    chk(n >= 3, "R6 period restarts", n, 3);

    // R9: disable mid-pulse
    enable = 1'b0; step();
    chk(wave_out == 1'b0, "R9 idle after disable", wave_out, 0);
    chk(cnt_out == 16'hFFFC, "R9 counter reload", cnt_out, 16'hFFFC);

    // R8: shadowed end value
    cmp_end = 16'd6; cmp_period = 16'd12; step();
    enable = 1'b1;
    while (wave_out != 1'b1) step();
    while (wave_out == 1'b1) step();
    while (wave_out != 1'b1) step();
    hi = 0;
    while (wave_out == 1'b1 && hi < 100) begin
      hi++;
      if (hi == 9) cmp_end = 16'd1;
      step();
    end
    chk(hi == 11, "R8 current pulse unchanged", hi, 11);
    measure(hi, lo, ef, pf);
    chk(hi == 6, "R8 new end value applied", hi, 6);
    chk(lo == 11, "R8 new inactive length", lo, 11);

    // single-shot mode
    enable = 1'b0; pwm_mode = 1'b0; cmp_end = 16'd3; trig_in = 1'b0; trig_rise = 1'b1;
    step(2);
    enable = 1'b1; step(3);
    chk(wave_out == 1'b0, "R4 no pulse without edge", wave_out, 0);
    fire_edge();
    chk(wave_out == 1'b1, "R2 rising edge starts pulse", wave_out, 1);
    chk(cnt_out == 16'hFFFC, "R10 reload at start", cnt_out, 16'hFFFC);
    hi = 0;
    while (wave_out == 1'b1 && hi < 100) begin
      hi++;
      if (hi == 3) trig_in = 1'b0;
      if (hi == 5) trig_in = 1'b1;
      step();
    end
    chk(hi == 8, "R3 R4 pulse length with retrigger", hi, 8);
    chk(match_end == 1'b1, "R3 end flag", match_end, 1);
    step();
    chk(match_end == 1'b0, "R3 end flag one cycle", match_end, 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (wave_out != 1'b0 || match_end) n++;
      step();
    end
    chk(n == 0, "R4 waits for new edge", n, 0);

    // falling-edge trigger
    trig_rise = 1'b0; step();
    fire_edge();
    chk(wave_out == 1'b1, "R2 falling edge starts pulse", wave_out, 1);
    hi = 0;
    while (wave_out == 1'b1 && hi < 100) begin hi++; step(); end
    chk(hi == 8, "R2 falling edge pulse length", hi, 8);

    // R7: tick stall
    trig_rise = 1'b1; trig_in = 1'b0; step(2);
    fire_edge();
    hi = 0; held = 16'h0;
    while (wave_out == 1'b1 && hi < 100) begin
      hi++;
      if (hi == 2) tick = 1'b0;
      if (hi == 4) held = cnt_out;
      if (hi == 11) chk(cnt_out == held, "R7 counter holds", cnt_out, held);
      if (hi == 12) tick = 1'b1;
      step();
    end
    chk(hi == 18, "R7 stalled pulse length", hi, 18);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule